// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block turns a handful of programmed numbers into the raster timing of a parallel LCD panel. It divides the system clock down to a pixel rate and walks a horizontal and a vertical position counter through sync, back porch, active area and front porch. It drives horizontal and vertical sync, a data-enable strobe and the active-area coordinates of the pixel being shown. A pixel fetch engine placed next to it uses the pixel-rate enable and the coordinates to know when, and which, pixel data is due.

Software programs it through a small write-only register port. The geometry it uses is copied into a working set only when a frame begins, so writing a register while the panel is being scanned never changes the current frame. Clearing the enable bit does not cut the picture. The frame in progress runs to its end, the block goes quiet, and a one-cycle completion pulse tells the system that the panel may be powered down or reprogrammed.

Top module: `lcdt_timing_gen`

## Requirements
- R1: `pix_ce` is high for exactly one clock in every Lq*Pq clocks, where Lq is the logic divider (divider word bits [23:16], 0 treated as 1) and Pq is the pixel divider (divider word bits [7:0], values below 2 treated as 2); all raster outputs change only on the clock edge that ends a cycle with `pix_ce` high.
- R2: Register addresses are 0 control (bit 0 = output enable), 1 horizontal word, 2 vertical word, 3 size word, 4 divider word. After reset the enable is 0, every geometry field is 0, the dividers are logic 1 and pixel 2, and `hsync`, `vsync`, `de`, `pos_x`, `pos_y`, `frame_done` are 0.
- R3: The horizontal word stores sync width minus one in bits [5:0] (1 to 64 pixels), front porch minus one in bits [15:8] and back porch minus one in bits [27:20] (1 to 256 pixels each); `hsync` is high for the sync width at the start of every line.
- R4: The vertical word stores sync width minus one in bits [5:0] (1 to 64 lines) while front porch in bits [15:8] and back porch in bits [27:20] hold the plain line count (0 to 255); `vsync` is high during the first sync-width lines of the frame.
- R5: The size word stores width minus one in bits [10:0] and height minus one in bits [26:16]; `de` is high for exactly width times height pixels per frame.
- R6: Both axes run in the order sync, back porch, active, front porch; the first `de` pixel of a frame lies at line vsync+vbp and pixel hsync+hbp, and `de` is never high together with a sync.
- R7: While `de` is high, `pos_x` counts the active pixel from 0; outside `de` it is 0. On active lines `pos_y` is the active line index from 0; on other lines it is 0.
- R8: Geometry writes take effect only at the start of the next frame; the frame in progress keeps its geometry.
- R9: Clearing the enable bit lets the current frame finish at full length; afterwards `hsync`, `vsync` and `de` stay 0 until the enable is set again.
- R10: `frame_done` is high for exactly one clock, in the clock after the final pixel of a frame that ends with the enable clear, and never otherwise.
- R11: From idle, a set enable starts a frame at the first pixel tick that follows, with position (0,0) shown from that tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel-rate clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable for active pixels |
| pos_x | output | 11 | Active pixel column |
| pos_y | output | 11 | Active line index |
| frame_done | output | 1 | One-cycle pulse when a stopped frame ends |

## Verification
A wrong position count or porch decode shows up within the same frame as a shifted or stretched sync, or as a first data-enable pixel at the wrong index. The bench therefore predicts every signal for every pixel of a frame and compares them pixel by pixel. A bad shadow load or stop decision only appears at the frame boundary, as a wrongly sized next frame, a missing or doubled completion pulse, or sync activity after the stop. These are checked in the first clocks after the last pixel. A divider fault is seen between the first two pixel ticks of the frame.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int ADDR_W  = 3;
  localparam int REG_W   = 32;
  localparam int SYNC_W  = 6;
  localparam int PORCH_W = 8;
  localparam int DIM_W   = 11;
  // longest axis: full sync + two full porches + full active span
  localparam int CNT_W   = $clog2((1 << SYNC_W) + 2 * (1 << PORCH_W) + (1 << DIM_W)) + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_HORZ = 3'd1,
    RA_VERT = 3'd2,
    RA_SIZE = 3'd3,
    RA_CDIV = 3'd4
  } lcdt_addr_e;

  typedef struct packed {
    logic [SYNC_W-1:0]  hsw_m1;
    logic [PORCH_W-1:0] hbp_m1;
    logic [PORCH_W-1:0] hfp_m1;
    logic [SYNC_W-1:0]  vsw_m1;
    logic [PORCH_W-1:0] vbp;
    logic [PORCH_W-1:0] vfp;
    logic [DIM_W-1:0]   wid_m1;
    logic [DIM_W-1:0]   hgt_m1;
  } lcdt_geom_t;

  typedef struct packed {
    cnt_t hs_end;
    cnt_t ha_beg;
    cnt_t ha_end;
    cnt_t htot;
    cnt_t vs_end;
    cnt_t va_beg;
    cnt_t va_end;
    cnt_t vtot;
  } lcdt_bounds_t;

  // Segment limits of one frame; horizontal fields are stored minus one,
  // vertical porches are stored as plain counts.
  function automatic lcdt_bounds_t calc_bounds(input lcdt_geom_t g);
    lcdt_bounds_t b;
    b.hs_end = cnt_t'(g.hsw_m1) + cnt_t'(1);
    b.ha_beg = b.hs_end + cnt_t'(g.hbp_m1) + cnt_t'(1);
    b.ha_end = b.ha_beg + cnt_t'(g.wid_m1) + cnt_t'(1);
    b.htot   = b.ha_end + cnt_t'(g.hfp_m1) + cnt_t'(1);
    b.vs_end = cnt_t'(g.vsw_m1) + cnt_t'(1);
    b.va_beg = b.vs_end + cnt_t'(g.vbp);
    b.va_end = b.va_beg + cnt_t'(g.hgt_m1) + cnt_t'(1);
    b.vtot   = b.va_end + cnt_t'(g.vfp);
    return b;
  endfunction

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output lcdt_geom_t           geom,
  output logic [DIV_W-1:0]     ldiv,
  output logic [DIV_W-1:0]     pdiv,
  output logic                 out_en
);

  localparam int LDIV_LSB = 16;

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[REG_W-1:28];

  always_ff @(posedge clk) begin
    if (rst) begin
      geom   <= '0;
      ldiv   <= DIV_W'(1);
      pdiv   <= DIV_W'(2);
      out_en <= 1'b0;
    end else if (wr_en) begin
      case (lcdt_addr_e'(wr_addr))
        RA_CTRL: out_en <= wr_data[0];
        RA_HORZ: begin
          geom.hsw_m1 <= wr_data[SYNC_W-1:0];
          geom.hfp_m1 <= wr_data[8 +: PORCH_W];
          geom.hbp_m1 <= wr_data[20 +: PORCH_W];
        end
        RA_VERT: begin
          geom.vsw_m1 <= wr_data[SYNC_W-1:0];
          geom.vfp    <= wr_data[8 +: PORCH_W];
          geom.vbp    <= wr_data[20 +: PORCH_W];
        end
        RA_SIZE: begin
          geom.wid_m1 <= wr_data[DIM_W-1:0];
          geom.hgt_m1 <= wr_data[16 +: DIM_W];
        end
        RA_CDIV: begin
          ldiv <= wr_data[LDIV_LSB +: DIV_W];
          pdiv <= wr_data[DIV_W-1:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int DIV_W    = 8,
  parameter int MIN_PDIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ldiv,
  input  logic [DIV_W-1:0] pdiv,
  output logic             tick
);

  logic [DIV_W-1:0] l_lim, p_lim;
  logic [DIV_W-1:0] lcnt, pcnt;

  // terminal counts, with the divider floors applied
  always_comb begin
    l_lim = (ldiv == '0) ? '0 : ldiv - DIV_W'(1);
    p_lim = (pdiv < DIV_W'(MIN_PDIV)) ? DIV_W'(MIN_PDIV - 1) : pdiv - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt <= '0;
      pcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (lcnt >= l_lim) begin
        lcnt <= '0;
        if (pcnt >= p_lim) begin
          pcnt <= '0;
          tick <= 1'b1;
        end else begin
          pcnt <= pcnt + DIV_W'(1);
        end
      end else begin
        lcnt <= lcnt + DIV_W'(1);
      end
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1

endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster
  import lcdt_pkg::*;
#(
  parameter int POS_W = DIM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             enable,
  input  lcdt_geom_t       geom_in,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [POS_W-1:0] x_o,
  output logic [POS_W-1:0] y_o,
  output logic             done_o
);

  logic         running, run_n;
  cnt_t         hcnt, vcnt, h_n, v_n;
  lcdt_geom_t   sh, g_use;
  lcdt_bounds_t cur, nb;
  logic         load, done_n, last_h, last_v;
  logic         hs_n, vs_n, hact, vact, de_n;
  cnt_t         xd, yd;

  assign cur    = calc_bounds(sh);
  assign last_h = (hcnt == cur.htot - cnt_t'(1));
  assign last_v = (vcnt == cur.vtot - cnt_t'(1));

  // position sequencing, advanced once per pixel tick
  always_comb begin
    run_n  = running;
    h_n    = hcnt;
    v_n    = vcnt;
    load   = 1'b0;
    done_n = 1'b0;
    if (tick) begin
      if (!running) begin
        if (enable) begin
          run_n = 1'b1;
          h_n   = '0;
          v_n   = '0;
          load  = 1'b1;
        end
      end else if (last_h && last_v) begin
        h_n = '0;
        v_n = '0;
        if (enable) begin
          load = 1'b1;
        end else begin
          run_n  = 1'b0;
          done_n = 1'b1;
        end
      end else if (last_h) begin
        h_n = '0;
        v_n = vcnt + cnt_t'(1);
      end else begin
        h_n = hcnt + cnt_t'(1);
      end
    end
  end

  assign g_use = load ? geom_in : sh;
  assign nb    = calc_bounds(g_use);

  always_comb begin
    hs_n = run_n && (h_n < nb.hs_end);
    vs_n = run_n && (v_n < nb.vs_end);
    hact = (h_n >= nb.ha_beg) && (h_n < nb.ha_end);
    vact = run_n && (v_n >= nb.va_beg) && (v_n < nb.va_end);
    de_n = hact && vact;
    xd   = de_n ? (h_n - nb.ha_beg) : '0;
    yd   = vact ? (v_n - nb.va_beg) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      sh      <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      done_o  <= 1'b0;
    end else begin
      running <= run_n;
      hcnt    <= h_n;
      vcnt    <= v_n;
      if (load) sh <= geom_in;
      hsync_o <= hs_n;
      vsync_o <= vs_n;
      de_o    <= de_n;
      x_o     <= xd[POS_W-1:0];
      y_o     <= yd[POS_W-1:0];
      done_o  <= done_n;
    end
  end

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({hsync_o, vsync_o, de_o, x_o, y_o})); // R1
  AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (!hsync_o && !vsync_o)); // R6
  AST_X_ZERO_OFF_DE: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (x_o == '0)); // R7
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !running |-> !(hsync_o || vsync_o || de_o)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_DONE_ONLY_STOPPED: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !running); // R10

endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
  import lcdt_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_PDIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              pix_ce,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [DIM_W-1:0]  pos_x,
  output logic [DIM_W-1:0]  pos_y,
  output logic              frame_done
);

  lcdt_geom_t       geom;
  logic [DIV_W-1:0] ldiv, pdiv;
  logic             out_en;

  lcdt_regs #(.DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .geom    (geom),
    .ldiv    (ldiv),
    .pdiv    (pdiv),
    .out_en  (out_en)
  );

  lcdt_pixdiv #(.DIV_W(DIV_W), .MIN_PDIV(MIN_PDIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .ldiv (ldiv),
    .pdiv (pdiv),
    .tick (pix_ce)
  );

  lcdt_raster #(.POS_W(DIM_W)) u_rast (
    .clk     (clk),
    .rst     (rst),
    .tick    (pix_ce),
    .enable  (out_en),
    .geom_in (geom),
    .hsync_o (hsync),
    .vsync_o (vsync),
    .de_o    (de),
    .x_o     (pos_x),
    .y_o     (pos_y),
    .done_o  (frame_done)
  );

endmodule

// File: tb/sim_lcdt_timing_gen.sv
module sim_lcdt_timing_gen;
  import lcdt_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [REG_W-1:0]  wr_data;
  logic              pix_ce, hsync, vsync, de, frame_done;
  logic [DIM_W-1:0]  pos_x, pos_y;

  lcdt_timing_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
    .pos_x(pos_x), .pos_y(pos_y), .frame_done(frame_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef int cfg_t [10];  // hsw hbp hfp vsw vbp vfp wid hgt ldiv pdiv
  localparam int NV = 5;
  localparam int VEC [NV][10] = '{
    '{ 1, 1,   1, 1, 0, 0, 1, 1, 1, 2},
    '{ 2, 3,   2, 2, 1, 2, 5, 3, 1, 2},
    '{ 4, 2,   3, 1, 2, 1, 8, 4, 3, 2},
    '{ 1, 1,   1, 3, 0, 0, 3, 2, 0, 1},
    '{64, 1, 256, 1, 0, 0, 2, 1, 1, 2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[ADDR_W-1:0];
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int enc_h(cfg_t c);
    return (c[0] - 1) | ((c[2] - 1) << 8) | ((c[1] - 1) << 20);
  endfunction
  function automatic int enc_v(cfg_t c);
    return (c[3] - 1) | (c[5] << 8) | (c[4] << 20);
  endfunction

  task automatic program_cfg(cfg_t c);
    wr(1, enc_h(c));
    wr(2, enc_v(c));
    wr(3, (c[6] - 1) | ((c[7] - 1) << 16));
    wr(4, (c[8] << 16) | c[9]);
  endtask

  // Follows one frame pixel by pixel, sampling at the negedge of each
  // pix_ce cycle, and compares against the geometry in c.
  task automatic run_frame(cfg_t c, bit stop, bit seek, bit midwr,
                           int wa, int wd, string tag);
    int hsw = c[0]; int hbp = c[1]; int hfp = c[2];
    int vsw = c[3]; int vbp = c[4]; int vfp = c[5];
    int wid = c[6]; int hgt = c[7];
    int htot = hsw + hbp + wid + hfp;
    int vtot = vsw + vbp + hgt + vfp;
    int total = htot * vtot;
    int per = (c[8] < 1 ? 1 : c[8]) * (c[9] < 2 ? 2 : c[9]);
    int hs_bad = 0, vs_bad = 0, de_bad = 0, xy_bad = 0, de_cnt = 0;
    int first_de = -1, c0 = 0, c1 = 0;
    if (seek) begin
      int g = 0;
      int idle_n = 0;
      do begin
        @(negedge clk);
        g++;
        if (pix_ce && !vsync) idle_n++;
      end while (!(pix_ce && vsync) && g < 20000);
      chk(idle_n <= 1, "R11", {tag, " idle ticks before frame start"}, idle_n, 1);
    end
    for (int idx = 0; idx < total; idx++) begin
      int h, v, ex, ey;
      bit ehs, evs, eha, eva, ede;
      if (idx > 0 || !seek) begin
        do @(negedge clk); while (!pix_ce);
      end
      if (idx == 0) c0 = cyc;
      if (idx == 1) c1 = cyc;
      h = idx % htot;
      v = idx / htot;
      ehs = (h < hsw);
      evs = (v < vsw);
      eha = (h >= hsw + hbp) && (h < hsw + hbp + wid);
      eva = (v >= vsw + vbp) && (v < vsw + vbp + hgt);
      ede = eha && eva;
      ex  = ede ? h - (hsw + hbp) : 0;
      ey  = eva ? v - (vsw + vbp) : 0;
      if (hsync !== ehs) hs_bad++;
      if (vsync !== evs) vs_bad++;
      if (de !== ede) de_bad++;
      if (de === 1'b1) begin
        de_cnt++;
        if (first_de < 0) first_de = idx;
      end
      if (int'(pos_x) != ex || int'(pos_y) != ey) xy_bad++;
      if (idx == 0 && stop) begin
        wr_en = 1'b1; wr_addr = '0; wr_data = '0;   // clear enable
        @(negedge clk);
        wr_en = 1'b0;
      end
      if (midwr && idx == total / 2) begin
        wr_en = 1'b1; wr_addr = wa[ADDR_W-1:0]; wr_data = wd;
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    chk(c1 - c0 == per, "R1", {tag, " pixel period"}, c1 - c0, per);
    chk(hs_bad == 0, "R3", {tag, " hsync mismatches"}, hs_bad, 0);
    chk(vs_bad == 0, "R4", {tag, " vsync mismatches"}, vs_bad, 0);
    chk(de_bad == 0 && de_cnt == wid * hgt, "R5", {tag, " de pixel count"}, de_cnt, wid * hgt);
    chk(first_de == (vsw + vbp) * htot + hsw + hbp, "R6", {tag, " first de index"},
        first_de, (vsw + vbp) * htot + hsw + hbp);
    chk(xy_bad == 0, "R7", {tag, " coordinate mismatches"}, xy_bad, 0);
    if (stop) begin
      int q = 0;
      @(negedge clk);
      chk(frame_done === 1'b1, "R10", {tag, " done after last pixel"}, int'(frame_done), 1);
      @(negedge clk);
      chk(frame_done === 1'b0, "R10", {tag, " done width"}, int'(frame_done), 0);
      repeat (3 * per) begin
        @(negedge clk);
        if (hsync || vsync || de || frame_done) q++;
      end
      chk(q == 0, "R9", {tag, " activity after stop"}, q, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_t c, ca, cb;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R2: outputs after reset
    chk({hsync, vsync, de, frame_done} == 4'b0, "R2", "sync/de/done after reset",
        int'({hsync, vsync, de, frame_done}), 0);
    chk(pos_x == '0 && pos_y == '0, "R2", "coordinates after reset",
        int'(pos_x) + int'(pos_y), 0);

    // R2: default registers give a 4x2 frame at a two-clock pixel rate
    c = VEC[0];
    wr(0, 1);
    run_frame(c, 1'b1, 1'b1, 1'b0, 0, 0, "defaults");

    // table walk
    for (int i = 0; i < NV; i++) begin
      c = VEC[i];
      program_cfg(c);
      wr(0, 1);
      run_frame(c, 1'b1, 1'b1, 1'b0, 0, 0, $sformatf("vec%0d", i));
    end

    // R8: horizontal write mid-frame lands only at the next frame
    ca = VEC[1];
    cb = VEC[1];
    cb[0] = 4; cb[1] = 2; cb[2] = 3;
    program_cfg(ca);
    wr(0, 1);
    run_frame(ca, 1'b0, 1'b1, 1'b1, 1, enc_h(cb), "R8 frame A");
    run_frame(cb, 1'b1, 1'b0, 1'b0, 0, 0, "R8 frame B");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule